// File: doc/BRIEF.md
# Receive Descriptor Ring Controller

This block is the device end of one receive descriptor ring that it shares with software. Software supplies a configuration word and a write index. The configuration word selects the run mode, the ring size, the buffer size, where interrupts go and an idle timeout. The write index marks one slot past the last empty buffer that software has posted.

The controller takes descriptors in ring order. For each one it requests the descriptor through a fetch handshake. It then streams incoming frame words into that buffer through a write port that passes words straight from the input to memory. When a buffer is closed, the controller publishes a read index one past that buffer. A buffer closes when the frame ends, when the buffer is full, or when the idle timeout expires.

An interrupt pulse marks each frame end and each timeout close. The idle flag tells software when the channel has stopped after it has been switched off or drained.

Top module: `rx_desc_ring`

## Requirements
- R1: While reset is held and after it is released with a zero configuration, `rd_idx` is 0, `irq` is 0, `fetch_req` is 0, `in_ready` is 0 and `idle` is 1.
- R2: The ring holds 2^N entries, where N is `cfg_word[23:20]` clamped into the range 5..12. Every index wraps from 2^N-1 to 0.
- R3: The effective write index is `sw_widx` with its low three bits forced to zero. A descriptor is fetched only while the current index differs from the effective write index, so equal indices mean that no buffer is free.
- R4: `fetch_req` stays high with a stable `fetch_idx` (the current descriptor) until `fetch_ack` arrives. No input word is accepted before that.
- R5: Buffer capacity in words is (`cfg_word[17:16]`+1) × UNIT_WORDS. A frame that fills a buffer continues at offset 0 of the next descriptor.
- R6: An accepted word with `in_last` closes the buffer. One cycle later `rd_idx` equals one past the closed descriptor, and `irq` pulses for one cycle when `cfg_word[13:12]` is 01.
- R7: When `cfg_word[13:12]` is not 01, `irq` stays low.
- R8: While a buffer holds data and no word arrives, a close happens after `cfg_word[11:4]` periods of TICK_DIV cycles and raises `irq`. Each accepted word restarts the count. A field value of 0 disables the timeout.
- R9: With mode `cfg_word[31:30]` = 00, no input is accepted and `idle` is 1 unless a fetch is outstanding.
- R10: With mode 01, a frame in progress is completed. After its last word, `in_ready` is 0 and `idle` is 1.
- R11: With no free descriptor, `in_ready` stays 0, which holds back the input.
- R12: Each accepted word appears on the write port in the same cycle, with `wr_desc` set to the current descriptor and `wr_offset` set to the word position inside the buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_word | input | 32 | Configuration: mode [31:30], ring log2 [23:20], buffer size [17:16], interrupt target [13:12], timeout [11:4] |
| sw_widx | input | IDX_W | Software write index (one past the last posted descriptor) |
| fetch_req | output | 1 | Descriptor fetch request |
| fetch_idx | output | IDX_W | Index of the descriptor being fetched |
| fetch_ack | input | 1 | Descriptor fetch completed |
| in_valid | input | 1 | Frame word valid |
| in_data | input | DATA_W | Frame word |
| in_last | input | 1 | Last word of the frame |
| in_ready | output | 1 | Frame word accepted this cycle when valid |
| wr_valid | output | 1 | Buffer write valid |
| wr_desc | output | IDX_W | Descriptor being written |
| wr_offset | output | CNT_W | Word offset inside the buffer |
| wr_data | output | DATA_W | Buffer write data |
| wr_ready | input | 1 | Memory accepts the write |
| rd_idx | output | IDX_W | Published read index (one past the last filled descriptor) |
| irq | output | 1 | One-cycle interrupt pulse |
| idle | output | 1 | Channel stopped |

## Verification
The assertions rely on several things software is expected to do. The ring-size field stays fixed while traffic flows. Buffer size changes only between frames. The write index never moves behind the device's read position. The stimulus respects all three. It programs the ring size once per phase and changes the buffer size only at frame boundaries. Before each frame it posts a write index 9 to 16 slots ahead of the modelled read position, in multiples of 8. The one exception is a deliberate sequence that fills the ring to the full condition.

// File: rtl/rdr_pkg.sv
`timescale 1ns/1ps
package rdr_pkg;
   typedef enum logic [1:0] {
      RUN_OFF   = 2'b00,
      RUN_DRAIN = 2'b01,
      RUN_ON    = 2'b10,
      RUN_RSVD  = 2'b11
   } run_mode_e;

   typedef enum logic [1:0] {
      ST_WAIT  = 2'b00,
      ST_FETCH = 2'b01,
      ST_FILL  = 2'b10
   } ring_state_e;

   localparam int MODE_LSB = 30;
   localparam int LOG_LSB  = 20;
   localparam int BSEL_LSB = 16;
   localparam int DEST_LSB = 12;
   localparam int TMO_LSB  = 4;
   localparam logic [1:0] DEST_HOST = 2'b01;
endpackage

// File: rtl/rdr_cfg_decode.sv
`timescale 1ns/1ps
module rdr_cfg_decode #(
   parameter int IDX_W      = 12,
   parameter int MIN_LOG    = 5,
   parameter int MAX_LOG    = 12,
   parameter int UNIT_WORDS = 1024,
   parameter int CNT_W      = 13
) (
   input  logic [31:0]          cfg_word,
   output rdr_pkg::run_mode_e   mode,
   output logic [IDX_W-1:0]     idx_mask,
   output logic [CNT_W-1:0]     cap_words,
   output logic                 irq_en,
   output logic [7:0]           tmo_units
);
   import rdr_pkg::*;

   logic [3:0]     log_raw;
   logic [3:0]     log_eff;
   logic [1:0]     bsel;
   logic [IDX_W:0] one_sh;
   logic [IDX_W:0] full_mask;
   logic           unused_cfg;

   assign log_raw = cfg_word[LOG_LSB +: 4];
   assign bsel    = cfg_word[BSEL_LSB +: 2];

   always_comb begin
      if (log_raw < 4'(MIN_LOG))      log_eff = 4'(MIN_LOG);
      else if (log_raw > 4'(MAX_LOG)) log_eff = 4'(MAX_LOG);
      else                            log_eff = log_raw;
   end

   assign one_sh    = (IDX_W+1)'(1) << log_eff;
   assign full_mask = one_sh - 1'b1;
   assign idx_mask  = full_mask[IDX_W-1:0];

   assign cap_words = CNT_W'((int'(bsel) + 1) * UNIT_WORDS);
   assign mode      = run_mode_e'(cfg_word[MODE_LSB +: 2]);
   assign irq_en    = (cfg_word[DEST_LSB +: 2] == DEST_HOST);
   assign tmo_units = cfg_word[TMO_LSB +: 8];

   assign unused_cfg = ^{cfg_word[29:24], cfg_word[19:18], cfg_word[15:14], cfg_word[3:0]};
endmodule

// File: rtl/rdr_idle_timer.sv
`timescale 1ns/1ps
module rdr_idle_timer #(
   parameter int TICK_DIV = 6400
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       restart,
   input  logic       arm,
   input  logic [7:0] tmo_units,
   output logic       expire
);
   logic [7:0] units_q;
   logic       tick;

   generate
      if (TICK_DIV <= 1) begin : g_no_div
         assign tick = 1'b1;
      end else begin : g_div
         localparam int PRE_W = $clog2(TICK_DIV);
         logic [PRE_W-1:0] pre_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                  pre_q <= '0;
            else if (restart || !arm)    pre_q <= '0;
            else if (tick)               pre_q <= '0;
            else                         pre_q <= pre_q + 1'b1;
         end
         assign tick = (pre_q == PRE_W'(TICK_DIV - 1));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         units_q <= '0;
      else if (restart || !arm)           units_q <= '0;
      else if (tick && units_q != 8'hFF)  units_q <= units_q + 1'b1;
   end

   assign expire = arm && (tmo_units != 8'd0) && (units_q == tmo_units);
endmodule

// File: rtl/rdr_ring_index.sv
`timescale 1ns/1ps
module rdr_ring_index #(
   parameter int IDX_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             advance,
   input  logic [IDX_W-1:0] idx_mask,
   output logic [IDX_W-1:0] cur,
   output logic [IDX_W-1:0] nxt
);
   assign nxt = (cur + 1'b1) & idx_mask;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cur <= '0;
      else if (advance) cur <= nxt;
   end
endmodule

// File: rtl/rx_desc_ring.sv
`timescale 1ns/1ps
module rx_desc_ring #(
   parameter int IDX_W      = 12,
   parameter int DATA_W     = 32,
   parameter int MIN_LOG    = 5,
   parameter int MAX_LOG    = 12,
   parameter int UNIT_WORDS = 1024,
   parameter int TICK_DIV   = 6400,
   localparam int CNT_W     = $clog2(4 * UNIT_WORDS + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [31:0]       cfg_word,
   input  logic [IDX_W-1:0]  sw_widx,
   output logic              fetch_req,
   output logic [IDX_W-1:0]  fetch_idx,
   input  logic              fetch_ack,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_data,
   input  logic              in_last,
   output logic              in_ready,
   output logic              wr_valid,
   output logic [IDX_W-1:0]  wr_desc,
   output logic [CNT_W-1:0]  wr_offset,
   output logic [DATA_W-1:0] wr_data,
   input  logic              wr_ready,
   output logic [IDX_W-1:0]  rd_idx,
   output logic              irq,
   output logic              idle
);
   import rdr_pkg::*;

   generate
      if (IDX_W < MAX_LOG)        begin : g_e0 $error("IDX_W must cover MAX_LOG"); end
      if (MIN_LOG < 3)            begin : g_e1 $error("ring must hold at least 8 entries"); end
      if (MAX_LOG > 15)           begin : g_e2 $error("MAX_LOG exceeds field range"); end
      if (MIN_LOG > MAX_LOG)      begin : g_e3 $error("MIN_LOG above MAX_LOG"); end
      if (UNIT_WORDS < 1)         begin : g_e4 $error("UNIT_WORDS must be positive"); end
      if (DATA_W < 1)             begin : g_e5 $error("DATA_W must be positive"); end
   endgenerate

   run_mode_e        mode;
   logic [IDX_W-1:0] idx_mask;
   logic [CNT_W-1:0] cap_words;
   logic             irq_en;
   logic [7:0]       tmo_units;

   rdr_cfg_decode #(
      .IDX_W(IDX_W), .MIN_LOG(MIN_LOG), .MAX_LOG(MAX_LOG),
      .UNIT_WORDS(UNIT_WORDS), .CNT_W(CNT_W)
   ) u_dec (
      .cfg_word(cfg_word), .mode(mode), .idx_mask(idx_mask),
      .cap_words(cap_words), .irq_en(irq_en), .tmo_units(tmo_units)
   );

   ring_state_e      state_q;
   logic [CNT_W-1:0] wcnt_q;
   logic             in_frame_q;
   logic [IDX_W-1:0] rd_q;
   logic             irq_q;
   logic [IDX_W-1:0] cur;
   logic [IDX_W-1:0] nxt;
   logic [IDX_W-1:0] widx_eff;
   logic             has_free;
   logic             run_ok;
   logic             filling;
   logic             acc;
   logic             fill_done;
   logic             tmo_close;
   logic             close;
   logic             expire;
   logic             unused_w;

   assign unused_w = ^sw_widx[2:0];
   assign widx_eff = {sw_widx[IDX_W-1:3], 3'b000} & idx_mask;
   assign has_free = (cur != widx_eff);
   assign run_ok   = (mode == RUN_ON) || (mode == RUN_DRAIN && in_frame_q);
   assign filling  = (state_q == ST_FILL) && run_ok;

   assign fetch_req = (state_q == ST_FETCH);
   assign fetch_idx = cur;
   assign in_ready  = filling && wr_ready;
   assign wr_valid  = filling && in_valid;
   assign wr_desc   = cur;
   assign wr_offset = wcnt_q;
   assign wr_data   = in_data;

   assign acc       = in_valid && in_ready;
   assign fill_done = acc && (in_last || (CNT_W'(wcnt_q + 1'b1) == cap_words));
   assign tmo_close = (state_q == ST_FILL) && !acc && expire;
   assign close     = fill_done || tmo_close;

   rdr_ring_index #(.IDX_W(IDX_W)) u_idx (
      .clk(clk), .rst_n(rst_n), .advance(close), .idx_mask(idx_mask),
      .cur(cur), .nxt(nxt)
   );

   rdr_idle_timer #(.TICK_DIV(TICK_DIV)) u_tmr (
      .clk(clk), .rst_n(rst_n), .restart(acc),
      .arm((state_q == ST_FILL) && (wcnt_q != '0)),
      .tmo_units(tmo_units), .expire(expire)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ST_WAIT;
         wcnt_q     <= '0;
         in_frame_q <= 1'b0;
         rd_q       <= '0;
         irq_q      <= 1'b0;
      end else begin
         irq_q <= irq_en && ((acc && in_last) || tmo_close);
         case (state_q)
            ST_WAIT:  if (run_ok && has_free) state_q <= ST_FETCH;
            ST_FETCH: if (fetch_ack)          state_q <= ST_FILL;
            ST_FILL:  if (close)              state_q <= ST_WAIT;
            default:                          state_q <= ST_WAIT;
         endcase
         if (acc) in_frame_q <= !in_last;
         if (close) begin
            wcnt_q <= '0;
            rd_q   <= nxt;
         end else if (acc) begin
            wcnt_q <= wcnt_q + 1'b1;
         end
      end
   end

   assign rd_idx = rd_q;
   assign irq    = irq_q;
   assign idle   = !run_ok && (state_q != ST_FETCH);
endmodule

// File: rtl/rdr_checker.sv
`timescale 1ns/1ps
module rdr_checker #(
   parameter int IDX_W      = 12,
   parameter int MIN_LOG    = 5,
   parameter int MAX_LOG    = 12,
   parameter int UNIT_WORDS = 1024,
   parameter int CNT_W      = 13
) (
   input logic             clk,
   input logic             rst_n,
   input logic [31:0]      cfg_word,
   input logic [IDX_W-1:0] sw_widx,
   input logic             fetch_req,
   input logic [IDX_W-1:0] fetch_idx,
   input logic             fetch_ack,
   input logic             in_valid,
   input logic             in_ready,
   input logic             wr_valid,
   input logic [CNT_W-1:0] wr_offset,
   input logic             wr_ready,
   input logic [IDX_W-1:0] rd_idx,
   input logic             irq,
   input logic             idle
);
   int               lg;
   logic [IDX_W-1:0] mask_c;
   logic [IDX_W-1:0] widx_c;
   int               cap_c;
   logic             unused_c;

   always_comb begin
      lg = int'(cfg_word[23:20]);
      if (lg < MIN_LOG) lg = MIN_LOG;
      if (lg > MAX_LOG) lg = MAX_LOG;
      mask_c = IDX_W'((64'd1 << lg) - 64'd1);
   end
   assign widx_c   = sw_widx & ~IDX_W'(7);
   assign cap_c    = (int'(cfg_word[17:16]) + 1) * UNIT_WORDS;
   assign unused_c = ^{cfg_word[29:24], cfg_word[19:18], cfg_word[15:14], cfg_word[11:0]};

   p_fetch_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_req && !fetch_ack |=> fetch_req && $stable(fetch_idx));

   p_no_input_in_fetch_r4: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_req |-> !in_ready);

   p_fetch_has_room_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fetch_req) |-> fetch_idx != ($past(widx_c) & $past(mask_c)));

   p_offset_in_cap_r5: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid |-> int'(wr_offset) < cap_c);

   p_read_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
      rd_idx != $past(rd_idx) |-> rd_idx == (($past(rd_idx) + 1'b1) & mask_c));

   p_no_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_word[13:12] != 2'b01 && $past(cfg_word[13:12]) != 2'b01) |-> !irq);

   p_off_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_word[31:30] == 2'b00 && !fetch_req) |-> idle);

   p_pass_through_r12: assert property (@(posedge clk) disable iff (!rst_n)
      in_ready |-> wr_ready && (wr_valid == in_valid));
endmodule

bind rx_desc_ring rdr_checker #(
   .IDX_W(IDX_W), .MIN_LOG(MIN_LOG), .MAX_LOG(MAX_LOG),
   .UNIT_WORDS(UNIT_WORDS), .CNT_W(CNT_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .cfg_word(cfg_word), .sw_widx(sw_widx),
   .fetch_req(fetch_req), .fetch_idx(fetch_idx), .fetch_ack(fetch_ack),
   .in_valid(in_valid), .in_ready(in_ready), .wr_valid(wr_valid),
   .wr_offset(wr_offset), .wr_ready(wr_ready), .rd_idx(rd_idx),
   .irq(irq), .idle(idle)
);

// File: tb/tb_rx_desc_ring.sv
`timescale 1ns/1ps
module tb_rx_desc_ring;
   localparam int IDX_W = 12, DATA_W = 32, UNIT_WORDS = 4, TICK_DIV = 4;
   localparam int CNT_W = $clog2(4 * UNIT_WORDS + 1);

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic              rst_n;
   logic [31:0]       cfg_word;
   logic [IDX_W-1:0]  sw_widx;
   logic              fetch_req, fetch_ack;
   logic [IDX_W-1:0]  fetch_idx;
   logic              in_valid, in_last, in_ready;
   logic [DATA_W-1:0] in_data;
   logic              wr_valid, wr_ready;
   logic [IDX_W-1:0]  wr_desc, rd_idx;
   logic [CNT_W-1:0]  wr_offset;
   logic [DATA_W-1:0] wr_data;
   logic              irq, idle;

   rx_desc_ring #(.IDX_W(IDX_W), .DATA_W(DATA_W), .UNIT_WORDS(UNIT_WORDS),
                  .TICK_DIV(TICK_DIV)) dut (
      .clk(clk), .rst_n(rst_n), .cfg_word(cfg_word), .sw_widx(sw_widx),
      .fetch_req(fetch_req), .fetch_idx(fetch_idx), .fetch_ack(fetch_ack),
      .in_valid(in_valid), .in_data(in_data), .in_last(in_last), .in_ready(in_ready),
      .wr_valid(wr_valid), .wr_desc(wr_desc), .wr_offset(wr_offset),
      .wr_data(wr_data), .wr_ready(wr_ready), .rd_idx(rd_idx), .irq(irq), .idle(idle));

   int n_chk = 0, n_fail = 0;
   int cur_m = 0, off_m = 0, mask_m = 31, cap_m = 4, irq_exp = 0, irq_seen = 0, wraps = 0;
   bit irq_on_m = 1'b1, auto_ack = 1'b1, done = 1'b0;

   task automatic check(bit ok, string req, int act, int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic int mask_of(int lg);
      int e = (lg < 5) ? 5 : (lg > 12) ? 12 : lg;
      return (1 << e) - 1;
   endfunction

   task automatic set_cfg(int mode, int lg, int bsel, int dest, int tmo);
      cfg_word = (32'(mode) << 30) | (32'(lg) << 20) | (32'(bsel) << 16) |
                 (32'(dest) << 12) | (32'(tmo) << 4);
      mask_m   = mask_of(lg);
      cap_m    = (bsel + 1) * UNIT_WORDS;
      irq_on_m = (dest == 1);
   endtask

   task automatic post();
      sw_widx = IDX_W'(((cur_m + 16) & ~7) & mask_m);
   endtask

   task automatic adv_model();
      if (cur_m == mask_m) wraps++;
      cur_m = (cur_m + 1) & mask_m;
      off_m = 0;
   endtask

   task automatic beat(logic [DATA_W-1:0] d, bit last);
      int guard = 0;
      bit ok;
      @(negedge clk);
      in_valid = 1'b1; in_data = d; in_last = last;
      wr_ready = ($urandom_range(0, 3) != 0);
      #1;
      while (!in_ready && guard < 2000) begin
         @(negedge clk);
         wr_ready = ($urandom_range(0, 3) != 0);
         #1;
         guard++;
      end
      ok = in_ready && wr_valid && (int'(wr_desc) == cur_m) &&
           (int'(wr_offset) == off_m) && (wr_data == d);
      check(ok, "R12 write port desc", int'(wr_desc), cur_m);
      if (ok) check(1'b1, "R5 offset", int'(wr_offset), off_m);
      else    check(1'b0, "R5 offset", int'(wr_offset), off_m);
      @(posedge clk); #1;
      in_valid = 1'b0; in_last = 1'b0;
      off_m++;
      if (last || off_m == cap_m) begin
         if (last && irq_on_m) irq_exp++;
         adv_model();
      end
   endtask

   task automatic frame(int len, string req);
      for (int i = 0; i < len; i++) beat($urandom(), i == len - 1);
      repeat (3) @(negedge clk);
      check(int'(rd_idx) == cur_m, req, int'(rd_idx), cur_m);
   endtask

   always @(negedge clk) if (rst_n && irq) irq_seen++;

   always @(negedge clk)
      fetch_ack = auto_ack && fetch_req && ($urandom_range(0, 1) == 1);

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual 1 expected 0");
         finish_run();
      end
   end

   initial begin
      void'($urandom(32'h5eed_1234));
      rst_n = 1'b0; cfg_word = '0; sw_widx = '0; fetch_ack = 1'b0;
      in_valid = 1'b0; in_data = '0; in_last = 1'b0; wr_ready = 1'b1;
      repeat (4) @(negedge clk);
      check(rd_idx == 0 && irq == 0 && fetch_req == 0 && in_ready == 0 && idle == 1,
            "R1 reset held", int'(idle), 1);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      check(rd_idx == 0 && irq == 0 && fetch_req == 0 && in_ready == 0 && idle == 1,
            "R1 after reset", int'(rd_idx), 0);

      // R3: equal indices and unaligned write index give no fetch
      set_cfg(2, 5, 0, 1, 0);
      sw_widx = 0;
      repeat (10) @(negedge clk);
      check(fetch_req == 0, "R3 equal indices", int'(fetch_req), 0);
      sw_widx = 5;
      repeat (10) @(negedge clk);
      check(fetch_req == 0, "R3 low bits ignored", int'(fetch_req), 0);
      // R4: fetch held, no input before ack
      auto_ack = 1'b0;
      sw_widx = 8;
      repeat (6) @(negedge clk);
      check(fetch_req == 1 && fetch_idx == 0, "R4 fetch request", int'(fetch_idx), 0);
      in_valid = 1'b1; #1;
      check(in_ready == 0, "R4 no input before ack", int'(in_ready), 0);
      in_valid = 1'b0;
      auto_ack = 1'b1;

      // R11: fill to the full point
      for (int i = 0; i < 8; i++) frame(1, "R6 read index");
      repeat (10) @(negedge clk);
      in_valid = 1'b1; #1;
      check(fetch_req == 0 && in_ready == 0, "R11 ring full stall", int'(in_ready), 0);
      in_valid = 1'b0;
      check(irq_seen == irq_exp, "R6 irq count", irq_seen, irq_exp);

      // R5: frames spanning several buffers
      post(); frame(10, "R5 span cap 4");
      set_cfg(2, 5, 2, 1, 0);
      post(); frame(13, "R5 span cap 12");

      // R8: timeout closes a partial buffer
      set_cfg(2, 5, 0, 1, 3);
      post();
      beat(32'h11, 1'b0); beat(32'h22, 1'b0);
      repeat (10) @(negedge clk);
      check(int'(rd_idx) == cur_m, "R8 not early", int'(rd_idx), cur_m);
      repeat (6) @(negedge clk);
      check(int'(rd_idx) == ((cur_m + 1) & mask_m), "R8 timeout close",
            int'(rd_idx), (cur_m + 1) & mask_m);
      adv_model(); irq_exp++;
      frame(1, "R8 frame tail after timeout");
      set_cfg(2, 5, 0, 1, 0);
      post();
      beat(32'h33, 1'b0); beat(32'h44, 1'b0);
      repeat (60) @(negedge clk);
      check(int'(rd_idx) == cur_m, "R8 zero disables", int'(rd_idx), cur_m);
      frame(1, "R8 zero finish");

      // R9: off mode stops input
      post();
      beat(32'h55, 1'b0); beat(32'h66, 1'b0);
      set_cfg(0, 5, 0, 1, 0);
      @(negedge clk); in_valid = 1'b1; #1;
      check(in_ready == 0 && idle == 1, "R9 off stops input", int'(in_ready), 0);
      in_valid = 1'b0;
      set_cfg(2, 5, 0, 1, 0);
      frame(1, "R9 resume");

      // R10: drain mode finishes the frame
      post();
      beat(32'h77, 1'b0); beat(32'h88, 1'b0);
      set_cfg(1, 5, 0, 1, 0);
      @(negedge clk); #1;
      check(idle == 0, "R10 busy mid-frame", int'(idle), 0);
      frame(3, "R10 drained frame");
      in_valid = 1'b1; #1;
      check(idle == 1 && in_ready == 0, "R10 idle after frame", int'(idle), 1);
      in_valid = 1'b0;

      // R7: no interrupt target
      set_cfg(2, 5, 0, 0, 0);
      post(); frame(3, "R7 frame");
      repeat (3) @(negedge clk);
      check(irq_seen == irq_exp, "R7 no irq", irq_seen, irq_exp);

      // R2: random traffic on a clamped 32-entry ring
      for (int f = 0; f < 40; f++) begin
         set_cfg(2, 3, $urandom_range(0, 3), 1, 0);
         post();
         frame($urandom_range(1, 3 * cap_m), "R2 random read index");
      end
      check(wraps > 0, "R2 wrap seen", wraps, 1);
      repeat (3) @(negedge clk);
      check(irq_seen == irq_exp, "R6 irq total", irq_seen, irq_exp);

      done = 1'b1;
      finish_run();
   end
endmodule